// File: doc/BRIEF.md
# Self-Timed Byte-Write Memory

This block models a 2048-word by 8-bit nonvolatile memory behind a pin-style control interface. Three active-low strobes select the operation: chip select, output enable and write strobe. An 11-bit address and an 8-bit data path complete the interface, with the data path split into an input, an output and an output-drive enable. All pins are sampled on a free-running clock. A read is purely combinational from the sampled pins and the stored contents.

A write begins when the chip select and the write strobe are both low and the output enable is high. The address is captured on the first cycle of that window. The data is followed until the window closes, so the value present on the last cycle of the window is the one stored. After the window closes, an internal counter runs for a fixed number of clock cycles, and the byte is committed to the array when the count ends. From the start of the window until the commit, the ready output is held low. During that time a read returns a polling pattern instead of stored data, and new write strobes are ignored. Writes never start while the low-supply flag is high.

Top module: `bytewrite_nvmem`

## Requirements
- R1: The array holds 2048 independent bytes selected by an 11-bit address. Address 0 and address 2047 both store and return their own values.
- R2: With chip select low, output enable low and write strobe high, `dout_en` is 1 and `dout` carries the addressed byte.
- R3: A write started by the write strobe falling, with chip select already low and output enable high, stores to the address present on the first cycle of the window. Later address changes have no effect on where the byte is stored.
- R4: A write started by chip select falling, with the write strobe already low and output enable high, is accepted in the same way.
- R5: The stored byte is the value on `din` in the last cycle that chip select and the write strobe are both low.
- R6: With chip select high, `dout_en` is 0 and no write starts, whatever the other pins do.
- R7: With both the write strobe and output enable high, `dout_en` is 0 and no write starts.
- R8: `ready` is 1 after reset. It goes to 0 the cycle after a write starts and stays 0 until TWC cycles after the window closes. The new byte is readable once `ready` returns to 1.
- R9: A read while `ready` is 0 returns the complement of bit 7 of the byte being written on bit 7, with bits 6 to 0 equal to 0.
- R10: While `supply_low` is 1, no write starts, and `ready` stays 1.
- R11: Write windows that open while `ready` is 0 are ignored. They neither restart the cycle nor replace the latched address or data.
- R12: With chip select, write strobe and output enable all low, no write starts and `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| supply_low | input | 1 | Supply below the write-inhibit level; blocks writes |
| addr | input | 11 | Byte address |
| din | input | 8 | Data driven into the block |
| dout | output | 8 | Data driven out of the block |
| dout_en | output | 1 | Output drive enable for the data bus |
| ready | output | 1 | 1 = ready, 0 = busy (pull-low style) |

## Verification
The bench targets write windows where the address moves after the start and the data changes on the last cycle. A design that latched the address late, or took the data too early, would store the wrong byte at the wrong place. It opens write windows while the block is busy. A design that re-armed on them would stretch the busy time or overwrite the latch. It reads during the timed cycle and checks the complemented bit 7, which a design that forwarded the array or the raw data would get wrong. It also holds the strobe low across the end of a cycle, where a level-triggered start would launch an unwanted second write. Finally, it drives inhibit, standby and low-supply pin states, in which a decoder that was too loose would drive the bus or write.

// File: rtl/bytewrite_nvmem.sv
module bytewrite_nvmem #(
  parameter int AW  = 11,
  parameter int DW  = 8,
  parameter int TWC = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          supply_low,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          ready
);
  localparam int WORDS = 1 << AW;
  localparam int CW = (TWC > 1) ? $clog2(TWC) : 1;

  typedef enum logic [1:0] {IDLE, PEND, BUSY} st_t;

  st_t           st;
  logic          win, win_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] mem [WORDS];

  assign win     = !ce_n && !we_n && oe_n;
  assign ready   = (st == IDLE);
  assign dout_en = !ce_n && !oe_n && we_n;

  wire start  = ready && win && !win_q && !supply_low;
  wire commit = (st == BUSY) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      win_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      cnt    <= '0;
    end else begin
      win_q <= win;
      case (st)
        IDLE: if (start) begin
          st     <= PEND;
          addr_q <= addr;
          data_q <= din;
        end
        PEND: if (win) data_q <= din;
              else begin
                st  <= BUSY;
                cnt <= CW'(TWC - 1);
              end
        BUSY: if (commit) st <= IDLE;
              else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && commit) mem[addr_q] <= data_q;
  end

  always_comb begin
    dout = '0;
    if (dout_en) begin
      if (!ready) dout = {~data_q[DW-1], {(DW-1){1'b0}}};
      else        dout = mem[addr];
    end
  end

  // R6
  standby_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en);

  // R7
  inhibit_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n && oe_n) |-> !dout_en);

  // R10
  low_supply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && supply_low) |=> ready);

  // R11
  busy_latch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BUSY && $past(st == BUSY)) |-> ($stable(addr_q) && $stable(data_q)));

  // R8
  commit_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (mem[addr_q] == data_q));

  // R9
  poll_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && dout_en) |-> (dout[DW-1] != data_q[DW-1]));
endmodule

// File: tb/bytewrite_nvmem_test.sv
module bytewrite_nvmem_test;
  localparam int TWC = 20;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        ce_n = 1, oe_n = 1, we_n = 1, supply_low = 0;
  logic [10:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en, ready;

  int checks = 0, errors = 0, cycles = 0;

  bytewrite_nvmem #(.AW(11), .DW(8), .TWC(TWC)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .supply_low(supply_low), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .ready(ready));

  always #5 clk = ~clk;

  // behavioural reference
  int        ms = 0, mc = 0;
  bit        mprev = 0;
  logic [10:0] ma;
  logic [7:0]  md;
  bit [7:0]  mm [int];

  always @(posedge clk) begin
    bit wr;
    wr = !ce_n && !we_n && oe_n;
    if (!rst_n) begin ms = 0; mprev = 0; end
    else begin
      case (ms)
        0: if (wr && !mprev && !supply_low) begin ms = 1; ma = addr; md = din; end
        1: if (wr) md = din; else begin ms = 2; mc = TWC; end
        default: begin mc--; if (mc == 0) begin mm[int'(ma)] = md; ms = 0; end end
      endcase
      mprev = wr;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit en;
      en = !ce_n && !oe_n && we_n;
      chk("R8 ready", int'(ready), (ms == 0) ? 1 : 0);
      chk("R2 dout_en", int'(dout_en), int'(en));
      if (en) begin
        if (ms != 0) chk("R9 poll", int'(dout), int'({~md[7], 7'b0}));
        else if (mm.exists(int'(addr))) chk("R2 data", int'(dout), int'(mm[int'(addr)]));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic pins_idle();
    ce_n = 1; oe_n = 1; we_n = 1;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 200 && !ready; i++) step();
  endtask

  task automatic we_write(input logic [10:0] a, input logic [7:0] d, input int len);
    pins_idle(); ce_n = 0; addr = a; din = ~d; step();
    we_n = 0; step();
    addr = ~a;
    for (int i = 1; i < len; i++) step();
    din = d; step();
    we_n = 1; step();
    pins_idle(); addr = a;
  endtask

  task automatic ce_write(input logic [10:0] a, input logic [7:0] d);
    pins_idle(); we_n = 0; addr = a; din = d; step();
    ce_n = 0; step(3);
    ce_n = 1; step();
    pins_idle();
  endtask

  task automatic read_chk(input string tag, input logic [10:0] a, input logic [7:0] e);
    ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    @(negedge clk);
    chk(tag, int'(dout_en), 1);
    chk(tag, int'(dout), int'(e));
    step();
    pins_idle();
  endtask

  initial begin
    step(2);
    chk("R8 reset ready", int'(ready), 1);
    chk("R6 reset dout_en", int'(dout_en), 0);
    rst_n = 1; step();

    // R3 and R5: write-strobe start, address moves, data final cycle
    we_write(11'd0, 8'h3C, 4);
    chk("R8 busy", int'(ready), 0);
    // R9 poll during cycle
    ce_n = 0; oe_n = 0; we_n = 1; addr = 11'd5;
    @(negedge clk);
    chk("R9 poll", int'(dout), 8'h80);
    step(); pins_idle();
    // R11 window while busy
    ce_n = 0; addr = 11'd9; din = 8'hFF; step(); we_n = 0; step(2); we_n = 1; step(); pins_idle();
    wait_ready();
    chk("R8 ready back", int'(ready), 1);
    read_chk("R3 R5 readback", 11'd0, 8'h3C);
    read_chk("R11 untouched addr", 11'd0, 8'h3C);

    // R4 chip-select start, R1 top address
    ce_write(11'd2047, 8'hA5);
    ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk);
    chk("R9 poll bit7 set", int'(dout), 8'h00);
    step(); pins_idle();
    wait_ready();
    read_chk("R4 R1 top", 11'd2047, 8'hA5);
    read_chk("R1 bottom", 11'd0, 8'h3C);

    // R10 low supply
    supply_low = 1;
    we_write(11'd0, 8'h11, 2);
    chk("R10 ready stays", int'(ready), 1);
    supply_low = 0; step();
    read_chk("R10 no write", 11'd0, 8'h3C);

    // R6 standby
    ce_n = 1; oe_n = 0; we_n = 0; addr = 11'd0; din = 8'h22; step(2);
    chk("R6 no drive", int'(dout_en), 0);
    chk("R6 no start", int'(ready), 1);
    pins_idle(); step();
    read_chk("R6 data kept", 11'd0, 8'h3C);

    // R7 inhibit
    ce_n = 0; oe_n = 1; we_n = 1; step(2);
    chk("R7 no drive", int'(dout_en), 0);
    chk("R7 no start", int'(ready), 1);

    // R12 all low
    ce_n = 0; oe_n = 0; we_n = 0; addr = 11'd0; din = 8'h44; step(3);
    chk("R12 no drive", int'(dout_en), 0);
    chk("R12 no start", int'(ready), 1);
    pins_idle(); step();
    read_chk("R12 data kept", 11'd0, 8'h3C);

    // R11 strobe held low across end of cycle: no second write
    pins_idle(); ce_n = 0; addr = 11'd7; din = 8'h5A; step();
    we_n = 0; step(2);
    ce_n = 0; oe_n = 1; // keep window open past the cycle? window closes only when we_n rises
    we_n = 1; step();
    ce_n = 0; we_n = 0; din = 8'h99; addr = 11'd8;
    step(TWC + 6);
    chk("R11 held strobe no restart", int'(ready), 1);
    pins_idle(); step();
    read_chk("R11 first byte", 11'd7, 8'h5A);

    step(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule